// File: doc/BRIEF.md
# Linked-List Descriptor Fetch Engine

This block walks a chain of DMA descriptors kept in system memory. For each descriptor it issues one read burst on a dedicated 64-bit AXI4 read channel. It unpacks the six returned words into source and destination addresses, row and byte counts and per-row strides, and presents them as a single command to a downstream transfer engine over a valid/ready port. It then waits for that engine to report the segment finished. At that point it either follows the embedded next pointer or, if the descriptor is flagged as the last one, returns to idle.

Software arms a chain by placing the first descriptor's 64-bit address on two 32-bit words and pulsing a submit strobe while descriptor mode is on. A descriptor can request an end-of-segment interrupt, which is reported together with the descriptor's identifier. A read error on any beat aborts the chain and raises an error flag. Because a chain can point back to an earlier descriptor, the plain repeat mode is suppressed whenever descriptor mode is on.

Top module: `sg_desc_walker`

## Requirements
- R1: A submit pulse seen while `hw_desc_en` is 1 and `busy` is 0 sets `busy` and, on the next cycle, presents a read request at address `{first_addr_hi, first_addr_lo}`.
- R2: Each read request is a single incrementing burst of six 8-byte beats: `ar_len`=5, `ar_size`=3, `ar_burst`=1. Once `ar_valid` is raised, it and `ar_addr` hold until `ar_ready`.
- R3: The beats are unpacked as follows, with the lower half-word being bits [31:0]. Beat 0 carries the flags in the low half and the id in the high half. Beat 1 is the destination address, beat 2 the source address and beat 3 the next-descriptor address. Beat 4 carries the row count minus one in the low half and the byte count minus one in the high half. Beat 5 carries the source stride in the low half and the destination stride in the high half.
- R4: `cmd_valid` rises only after all six beats are received and holds with stable fields until `cmd_ready`. No new read request is issued before the command is accepted and `seg_done` has been seen.
- R5: When flags bit 0 is 0, the cycle after `seg_done` presents a read request at the descriptor's next-descriptor address.
- R6: When flags bit 0 is 1, the cycle after `seg_done` shows `busy`=0 and a one-cycle `chain_done` pulse.
- R7: The cycle after `seg_done`, `irq` pulses for one cycle with `irq_id` equal to the descriptor id if flags bit 1 is 1. Otherwise `irq` stays 0.
- R8: A submit is ignored while `busy` is 1 or `hw_desc_en` is 0. The read address in flight and the next address followed are not changed by it.
- R9: A non-zero `r_resp` on any beat ends the chain after the sixth beat: `err` becomes 1, `busy` 0, and no command is issued. `err` clears on the next accepted submit.
- R10: `cyclic_active` equals `cyclic_en` while `hw_desc_en` is 0 and is 0 while `hw_desc_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_desc_en | input | 1 | Descriptor mode enable |
| cyclic_en | input | 1 | Repeat-mode request from the register file |
| cyclic_active | output | 1 | Repeat mode actually in effect |
| first_addr_hi | input | 32 | Upper word of first descriptor address |
| first_addr_lo | input | 32 | Lower word of first descriptor address |
| submit | input | 1 | Start strobe |
| busy | output | 1 | A chain is in progress |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | output | 64 | Descriptor address |
| ar_len | output | 8 | Burst length minus one |
| ar_size | output | 3 | Beat size code |
| ar_burst | output | 2 | Burst type |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data ready |
| r_data | input | 64 | Read data |
| r_resp | input | 2 | Read response |
| r_last | input | 1 | Last beat of burst |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted |
| cmd_src | output | 64 | Source address |
| cmd_dst | output | 64 | Destination address |
| cmd_xlen | output | 32 | Bytes per row minus one |
| cmd_ylen | output | 32 | Rows minus one |
| cmd_src_stride | output | 32 | Source row stride |
| cmd_dst_stride | output | 32 | Destination row stride |
| cmd_id | output | 32 | Descriptor identifier |
| seg_done | input | 1 | Segment finished pulse from the transfer engine |
| irq | output | 1 | Per-descriptor interrupt pulse |
| irq_id | output | 32 | Identifier of the interrupting descriptor |
| chain_done | output | 1 | Pulse when the last descriptor finishes |
| err | output | 1 | Chain aborted on a read error |

## Verification
A submit shows up as `busy` and `ar_valid` one clock later. The command appears one clock after the edge that takes the sixth beat. `irq`, `chain_done`, `err` and the next read request are all due one clock after the edge that samples `seg_done` or the final beat. The bench drives every input on the falling edge and reads outputs on the next falling edge, so each check lands exactly one register stage after its cause. Holding checks are repeated on each falling edge of a random stall.

// File: rtl/sg_desc_walker.sv
module sg_desc_walker #(
  parameter int AW = 64,
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_desc_en,
  input  logic          cyclic_en,
  output logic          cyclic_active,
  input  logic [WW-1:0] first_addr_hi,
  input  logic [WW-1:0] first_addr_lo,
  input  logic          submit,
  output logic          busy,
  output logic          ar_valid,
  input  logic          ar_ready,
  output logic [AW-1:0] ar_addr,
  output logic [7:0]    ar_len,
  output logic [2:0]    ar_size,
  output logic [1:0]    ar_burst,
  input  logic          r_valid,
  output logic          r_ready,
  input  logic [2*WW-1:0] r_data,
  input  logic [1:0]    r_resp,
  input  logic          r_last,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [AW-1:0] cmd_src,
  output logic [AW-1:0] cmd_dst,
  output logic [WW-1:0] cmd_xlen,
  output logic [WW-1:0] cmd_ylen,
  output logic [WW-1:0] cmd_src_stride,
  output logic [WW-1:0] cmd_dst_stride,
  output logic [WW-1:0] cmd_id,
  input  logic          seg_done,
  output logic          irq,
  output logic [WW-1:0] irq_id,
  output logic          chain_done,
  output logic          err
);
  localparam int BEATS = 6;
  localparam int BW = $clog2(BEATS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_CMD, S_WAIT} st_t;
  st_t st;
  logic [BW-1:0] beat;
  logic          bad, f_last, f_irq;
  logic [AW-1:0] fetch_addr, nxt;
  wire           last_beat = (beat == BW'(BEATS - 1));
  wire [WW-1:0]  lo = r_data[WW-1:0];
  wire [WW-1:0]  hi = r_data[2*WW-1:WW];

  assign cyclic_active = cyclic_en & ~hw_desc_en;
  assign busy      = (st != S_IDLE);
  assign ar_valid  = (st == S_ADDR);
  assign ar_addr   = fetch_addr;
  assign ar_len    = 8'(BEATS - 1);
  assign ar_size   = 3'($clog2(2*WW/8));
  assign ar_burst  = 2'b01;
  assign r_ready   = (st == S_DATA);
  assign cmd_valid = (st == S_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; beat <= '0; bad <= 1'b0; f_last <= 1'b0; f_irq <= 1'b0;
      fetch_addr <= '0; nxt <= '0; cmd_src <= '0; cmd_dst <= '0;
      cmd_xlen <= '0; cmd_ylen <= '0; cmd_src_stride <= '0; cmd_dst_stride <= '0;
      cmd_id <= '0; irq <= 1'b0; irq_id <= '0; chain_done <= 1'b0; err <= 1'b0;
    end else begin
      irq <= 1'b0;
      chain_done <= 1'b0;
      case (st)
        S_IDLE: if (submit && hw_desc_en) begin
          fetch_addr <= {first_addr_hi, first_addr_lo};
          err <= 1'b0;
          st <= S_ADDR;
        end
        S_ADDR: if (ar_ready) begin
          beat <= '0;
          bad <= 1'b0;
          st <= S_DATA;
        end
        S_DATA: if (r_valid) begin
          beat <= beat + 1'b1;
          if (r_resp != 2'b00) bad <= 1'b1;
          case (beat)
            BW'(0): begin f_last <= lo[0]; f_irq <= lo[1]; cmd_id <= hi; end
            BW'(1): cmd_dst <= r_data;
            BW'(2): cmd_src <= r_data;
            BW'(3): nxt <= r_data;
            BW'(4): begin cmd_ylen <= lo; cmd_xlen <= hi; end
            default: begin cmd_src_stride <= lo; cmd_dst_stride <= hi; end
          endcase
          if (last_beat) begin
            if (bad || r_resp != 2'b00) begin
              err <= 1'b1;
              st <= S_IDLE;
            end else begin
              st <= S_CMD;
            end
          end
        end
        S_CMD: if (cmd_ready) st <= S_WAIT;
        S_WAIT: if (seg_done) begin
          irq <= f_irq;
          irq_id <= cmd_id;
          if (f_last) begin
            chain_done <= 1'b1;
            st <= S_IDLE;
          end else begin
            fetch_addr <= nxt;
            st <= S_ADDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_ar_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr));
  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_src) && $stable(cmd_dst) && $stable(cmd_xlen));
  p_no_fetch_with_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> !cmd_valid);
  p_irq_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(seg_done));
  p_chain_end_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> !busy && $past(seg_done));
  p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy && !cmd_valid);
endmodule

// File: tb/test_sg_desc_walker.sv
module test_sg_desc_walker;
  localparam time PERIOD = 10ns;
  localparam logic [63:0] BASE = 64'h0000_0012_3400_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hw_desc_en = 1'b0, cyclic_en = 1'b0, submit = 1'b0;
  logic [31:0] first_addr_hi = '0, first_addr_lo = '0;
  logic ar_ready = 1'b0, r_valid = 1'b0, r_last = 1'b0, cmd_ready = 1'b0, seg_done = 1'b0;
  logic [63:0] r_data = '0;
  logic [1:0] r_resp = '0;
  logic cyclic_active, busy, ar_valid, r_ready, cmd_valid, irq, chain_done, err;
  logic [63:0] ar_addr, cmd_src, cmd_dst;
  logic [7:0] ar_len;
  logic [2:0] ar_size;
  logic [1:0] ar_burst;
  logic [31:0] cmd_xlen, cmd_ylen, cmd_src_stride, cmd_dst_stride, cmd_id, irq_id;

  sg_desc_walker i_sg_desc_walker (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] d_flags[8], d_id[8], d_y[8], d_x[8], d_ss[8], d_ds[8];
  logic [63:0] d_dst[8], d_src[8], d_next[8];

  function automatic logic [63:0] addr_of(int s);
    return BASE + 64'(s) * 64;
  endfunction

  function automatic logic [63:0] beat_word(int s, int b);
    case (b)
      0: return {d_id[s], d_flags[s]};
      1: return d_dst[s];
      2: return d_src[s];
      3: return d_next[s];
      4: return {d_x[s], d_y[s]};
      default: return {d_ds[s], d_ss[s]};
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(int s, bit last, bit want_irq, int nxt_slot);
    d_flags[s] = {$urandom, 2'b00} | {30'd0, want_irq, last};
    d_id[s] = $urandom; d_y[s] = $urandom; d_x[s] = $urandom;
    d_ss[s] = $urandom; d_ds[s] = $urandom;
    d_dst[s] = {$urandom, $urandom}; d_src[s] = {$urandom, $urandom};
    d_next[s] = last ? {$urandom, $urandom} : addr_of(nxt_slot);
  endtask

  task automatic serve_fetch(int s, int bad_beat);
    while (!ar_valid) @(negedge clk);
    chk("R1/R5 ar_addr", ar_addr, addr_of(s));
    chk("R2 ar_len", 64'(ar_len), 64'd5);
    chk("R2 ar_size", 64'(ar_size), 64'd3);
    chk("R2 ar_burst", 64'(ar_burst), 64'd1);
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk("R2 ar hold", {63'd0, ar_valid}, 64'd1);
      chk("R2 ar_addr hold", ar_addr, addr_of(s));
    end
    ar_ready = 1'b1;
    @(negedge clk);
    ar_ready = 1'b0;
    for (int b = 0; b < 6; b++) begin
      repeat ($urandom % 3) @(negedge clk);
      chk("R4 no cmd mid-fetch", {63'd0, cmd_valid}, 64'd0);
      r_valid = 1'b1; r_data = beat_word(s, b); r_last = (b == 5);
      r_resp = (b == bad_beat) ? 2'b10 : 2'b00;
      while (!r_ready) @(negedge clk);
      @(negedge clk);
      r_valid = 1'b0; r_last = 1'b0; r_resp = 2'b00;
    end
  endtask

  task automatic check_cmd(int s);
    chk("R4 cmd_valid", {63'd0, cmd_valid}, 64'd1);
    chk("R4 no ar with cmd", {63'd0, ar_valid}, 64'd0);
    chk("R3 src", cmd_src, d_src[s]);
    chk("R3 dst", cmd_dst, d_dst[s]);
    chk("R3 xlen", 64'(cmd_xlen), 64'(d_x[s]));
    chk("R3 ylen", 64'(cmd_ylen), 64'(d_y[s]));
    chk("R3 src_stride", 64'(cmd_src_stride), 64'(d_ss[s]));
    chk("R3 dst_stride", 64'(cmd_dst_stride), 64'(d_ds[s]));
    chk("R3 id", 64'(cmd_id), 64'(d_id[s]));
  endtask

  task automatic pulse_submit(logic [63:0] a);
    first_addr_hi = a[63:32]; first_addr_lo = a[31:0];
    submit = 1'b1;
    @(negedge clk);
    submit = 1'b0;
  endtask

  task automatic run_chain(int n, int start);
    int s;
    for (int i = 0; i < n; i++) begin
      s = (start + i) % 8;
      fill(s, i == n - 1, ($urandom % 2) == 1, (start + i + 1) % 8);
    end
    pulse_submit(addr_of(start));
    chk("R1 busy", {63'd0, busy}, 64'd1);
    chk("R1 ar_valid", {63'd0, ar_valid}, 64'd1);
    for (int i = 0; i < n; i++) begin
      s = (start + i) % 8;
      serve_fetch(s, -1);
      check_cmd(s);
      repeat ($urandom % 3) begin
        @(negedge clk);
        chk("R4 cmd hold", {63'd0, cmd_valid}, 64'd1);
        chk("R4 cmd_src hold", cmd_src, d_src[s]);
      end
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      chk("R4 cmd drop", {63'd0, cmd_valid}, 64'd0);
      if (i == 0) pulse_submit(BASE + 64'h8000);
      else @(negedge clk);
      chk("R8 busy kept", {63'd0, busy}, 64'd1);
      repeat (1 + $urandom % 3) begin
        chk("R4 no fetch before done", {63'd0, ar_valid}, 64'd0);
        @(negedge clk);
      end
      seg_done = 1'b1;
      @(negedge clk);
      seg_done = 1'b0;
      chk("R7 irq", {63'd0, irq}, 64'(d_flags[s][1]));
      if (d_flags[s][1]) chk("R7 irq_id", 64'(irq_id), 64'(d_id[s]));
      chk("R6 chain_done", {63'd0, chain_done}, 64'(d_flags[s][0]));
      chk("R6 busy", {63'd0, busy}, 64'(!d_flags[s][0]));
      if (!d_flags[s][0]) begin
        chk("R5 next fetch", {63'd0, ar_valid}, 64'd1);
        chk("R5 R8 next addr", ar_addr, d_next[s]);
      end else begin
        @(negedge clk);
        chk("R7 irq one cycle", {63'd0, irq}, 64'd0);
        chk("R6 stays idle", {63'd0, busy}, 64'd0);
      end
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset busy", {63'd0, busy}, 64'd0);
    chk("R2 reset ar_valid", {63'd0, ar_valid}, 64'd0);
    chk("R4 reset cmd_valid", {63'd0, cmd_valid}, 64'd0);
    chk("R7 reset irq", {63'd0, irq}, 64'd0);
    chk("R9 reset err", {63'd0, err}, 64'd0);

    for (int c = 0; c < 4; c++) begin
      cyclic_en = c[0]; hw_desc_en = c[1];
      #1;
      chk("R10 cyclic_active", {63'd0, cyclic_active}, 64'(c[0] && !c[1]));
    end
    hw_desc_en = 1'b0; cyclic_en = 1'b0;
    @(negedge clk);
    pulse_submit(addr_of(0));
    chk("R8 submit with mode off", {63'd0, busy}, 64'd0);
    chk("R8 no fetch with mode off", {63'd0, ar_valid}, 64'd0);

    hw_desc_en = 1'b1;
    run_chain(1, 0);
    run_chain(4, 6);
    for (int k = 0; k < 8; k++) run_chain(1 + $urandom % 4, $urandom % 8);

    fill(3, 1'b0, 1'b1, 4);
    pulse_submit(addr_of(3));
    serve_fetch(3, 2);
    chk("R9 err", {63'd0, err}, 64'd1);
    chk("R9 idle", {63'd0, busy}, 64'd0);
    chk("R9 no cmd", {63'd0, cmd_valid}, 64'd0);
    @(negedge clk);
    chk("R9 no refetch", {63'd0, ar_valid}, 64'd0);
    fill(5, 1'b1, 1'b0, 0);
    pulse_submit(addr_of(5));
    chk("R9 err cleared", {63'd0, err}, 64'd0);
    serve_fetch(5, 5);
    chk("R9 err last beat", {63'd0, err}, 64'd1);
    run_chain(2, 1);
    chk("R9 clean chain", {63'd0, err}, 64'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule